// File: doc/BRIEF.md
# Audio Routing Control Register Slave

This block is the control port of an audio routing chip. A bus master writes it over a two-wire serial bus that is compatible with I2C. The block samples SCL and SDA with a fast system clock and detects START and STOP conditions. It then receives one address byte. If the address matches, it acknowledges by pulling SDA low through an open-drain enable, and it accepts exactly one data byte. The three most significant bits of that data byte name the register that the remaining bits load. The block is write-only and never answers a read request.

The register contents leave the block as parallel fields that drive the analog side:

- master power enable
- fast wake selection
- supply-reset guard
- right headphone shutdown
- routing mode
- earpiece mode
- headphone gain
- three input volume levels

A supply-low input can return every register to zero. A register bit enables or blocks that input. Writing the power enable bit has no effect on any other register.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After rst_n is released, every register output reads zero.
- R2: A transaction whose first byte is 8'hF8 (7-bit address 7'h7C with the read/write bit at 0) is acknowledged twice: sda_oe is high during the ninth SCL clock after the address byte and again after the data byte.
- R3: Any other first byte, including 8'hF9 (a read), is never acknowledged. SDA stays released for the rest of that transaction, and no register changes.
- R4: Data bits 7:5 select the target register, and the lower bits load its fields as follows:
  - 000, shutdown register: bit0 pwr_on, bit1 fast_wake, bit2 keep_on_low, bit4 hp_right_off.
  - 010, output mode register: bits 3:0 route_mode, bit4 ear_mode.
  - 100, headphone gain register: bits 2:0 hp_gain.
  - 101, 110, 111: bits 4:0 of vol_mono, vol_left and vol_right respectively.
- R5: Select codes 001 and 011 are acknowledged, but their data is discarded and no register changes.
- R6: A START that arrives inside a byte abandons that byte without any register update, and reception restarts with a new address byte.
- R7: Writing the shutdown register changes only the fields of that register. Toggling pwr_on leaves every other register as it was.
- R8: While keep_on_low is 0, asserting supply_low clears every register to zero on the next clock edge.
- R9: While keep_on_low is 1, supply_low has no effect on any register.
- R10: sda_oe changes only while SCL is low.
- R11: Only one data byte is accepted per transaction. Further bytes before STOP are not acknowledged and are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz for a 400 kHz bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain acknowledge) |
| supply_low | input | 1 | Interface supply has dropped |
| pwr_on | output | 1 | Master power enable |
| fast_wake | output | 1 | Short turn-on delay selected |
| keep_on_low | output | 1 | 1 blocks supply_low from clearing the registers |
| hp_right_off | output | 1 | Right headphone amplifier shut down |
| route_mode | output | 4 | Input-to-output routing mode |
| ear_mode | output | 1 | Earpiece path overrides the routing mode |
| hp_gain | output | 3 | Headphone output gain code |
| vol_mono | output | 5 | Mono input volume step |
| vol_left | output | 5 | Left input volume step |
| vol_right | output | 5 | Right input volume step |

## Verification
The assertions compare the timing of register updates and acknowledges against the raw scl_in pin. They therefore assume that every SCL low and high phase lasts far longer than the synchronizer delay. They also assume that no bus write completes while supply_low is held. The bench drives SCL with quarter-bit phases of 25 system clocks. It pulses supply_low only while the bus is idle between transactions. It forms SDA as the wired AND of the master's drive and the slave's open-drain enable.

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h7C,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       supply_low,
  output logic       pwr_on,
  output logic       fast_wake,
  output logic       keep_on_low,
  output logic       hp_right_off,
  output logic [3:0] route_mode,
  output logic       ear_mode,
  output logic [2:0] hp_gain,
  output logic [4:0] vol_mono,
  output logic [4:0] vol_left,
  output logic [4:0] vol_right
);
  localparam logic [7:0] MATCH = {DEV_ADDR, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_SKIP} state_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  state_t st;
  logic [3:0] cnt;
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_d  <= scl_sy[SYNC_STAGES-1];
      sda_d  <= sda_sy[SYNC_STAGES-1];
    end

  wire scl_s    = scl_sy[SYNC_STAGES-1];
  wire sda_s    = sda_sy[SYNC_STAGES-1];
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire wr_en    = (st == S_DACK) & scl_fall & ~start & ~stop;
  wire byte_end = scl_fall & (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
    end else if (start) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_DATA: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            if (st == S_DATA || sh == MATCH) begin
              sda_oe <= 1'b1;
              st     <= (st == S_ADDR) ? S_AACK : S_DACK;
            end else begin
              st <= S_SKIP;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_DATA;
        end
        S_DACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= S_SKIP;
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || (supply_low && !keep_on_low)) begin
      {pwr_on, fast_wake, keep_on_low, hp_right_off} <= '0;
      {ear_mode, route_mode} <= '0;
      hp_gain   <= '0;
      vol_mono  <= '0;
      vol_left  <= '0;
      vol_right <= '0;
    end else if (wr_en) begin
      case (sh[7:5])
        3'b000: {hp_right_off, keep_on_low, fast_wake, pwr_on} <= {sh[4], sh[2:0]};
        3'b010: {ear_mode, route_mode} <= sh[4:0];
        3'b100: hp_gain   <= sh[2:0];
        3'b101: vol_mono  <= sh[4:0];
        3'b110: vol_left  <= sh[4:0];
        3'b111: vol_right <= sh[4:0];
        default: ;
      endcase
    end
endmodule

// File: rtl/audio_ctl_i2c_checker.sv
module audio_ctl_i2c_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       supply_low,
  input logic       pwr_on,
  input logic       fast_wake,
  input logic       keep_on_low,
  input logic       hp_right_off,
  input logic [3:0] route_mode,
  input logic       ear_mode,
  input logic [2:0] hp_gain,
  input logic [4:0] vol_mono,
  input logic [4:0] vol_left,
  input logic [4:0] vol_right
);
  wire [26:0] regs = {pwr_on, fast_wake, keep_on_low, hp_right_off, route_mode,
                      ear_mode, hp_gain, vol_mono, vol_left, vol_right};

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  a_r8_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low && !keep_on_low) |=> (regs == 27'd0));

  a_r9_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low && keep_on_low) |=> keep_on_low);

  a_r4_update_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(regs) && !$past(supply_low)) |-> !scl_in);
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_checker u_chk (.*);

// File: tb/audio_ctl_i2c_slave_bench.sv
module audio_ctl_i2c_slave_bench;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, supply_low = 1'b0;
  logic sda_oe, pwr_on, fast_wake, keep_on_low, hp_right_off, ear_mode;
  logic [3:0] route_mode;
  logic [2:0] hp_gain;
  logic [4:0] vol_mono, vol_left, vol_right;
  wire sda_bus = sda_m & ~sda_oe;

  int vectors = 0, fails = 0;
  logic [26:0] ev = '0;

  always #5 clk = ~clk;

  audio_ctl_i2c_slave u_audio_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .supply_low(supply_low), .pwr_on(pwr_on), .fast_wake(fast_wake),
    .keep_on_low(keep_on_low), .hp_right_off(hp_right_off), .route_mode(route_mode),
    .ear_mode(ear_mode), .hp_gain(hp_gain), .vol_mono(vol_mono),
    .vol_left(vol_left), .vol_right(vol_right));

  wire [26:0] obs = {pwr_on, fast_wake, keep_on_low, hp_right_off, route_mode,
                     ear_mode, hp_gain, vol_mono, vol_left, vol_right};

  function automatic logic [26:0] model(input logic [26:0] s, input logic [7:0] d);
    logic [26:0] n = s;
    case (d[7:5])
      3'b000: begin n[26] = d[0]; n[25] = d[1]; n[24] = d[2]; n[23] = d[4]; end
      3'b010: begin n[22:19] = d[3:0]; n[18] = d[4]; end
      3'b100: n[17:15] = d[2:0];
      3'b101: n[14:10] = d[4:0];
      3'b110: n[9:5]   = d[4:0];
      3'b111: n[4:0]   = d[4:0];
      default: ;
    endcase
    return n;
  endfunction

  task automatic q; repeat (Q) @(negedge clk); endtask

  task automatic chk_regs(input string req);
    vectors++;
    if (obs !== ev) begin
      fails++;
      $display("FAIL %s regs actual=%h expected=%h", req, obs, ev);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic want);
    vectors++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s ack actual=%b expected=%b", req, got, want);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; q; scl_m = 1'b1; q; sda_m = 1'b0; q; scl_m = 1'b0; q;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; q; scl_m = 1'b1; q; sda_m = 1'b1; q; q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q; scl_m = 1'b1; q; q; scl_m = 1'b0; q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic k);
    send_bits(b, 8);
    sda_m = 1'b1; q; scl_m = 1'b1; q; k = ~sda_bus; q; scl_m = 1'b0; q;
  endtask

  task automatic xfer(input string req, input logic [7:0] a, input logic [7:0] d);
    logic k1, k2;
    i2c_start;
    send_byte(a, k1);
    send_byte(d, k2);
    i2c_stop;
    if (a == 8'hF8) ev = model(ev, d);
    chk_bit(req, k1, a == 8'hF8);
    chk_bit(req, k2, a == 8'hF8);
    chk_regs(req);
  endtask

  task automatic pulse_low;
    supply_low = 1'b1; repeat (3) @(negedge clk); supply_low = 1'b0; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic k;
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_regs("R1 reset state");

    xfer("R2 R4 shutdown", 8'hF8, 8'b000_10011);
    xfer("R4 output mode", 8'hF8, 8'b010_10110);
    xfer("R4 hp gain", 8'hF8, 8'b100_00101);
    xfer("R4 mono vol", 8'hF8, 8'b101_11001);
    xfer("R4 left vol", 8'hF8, 8'b110_00111);
    xfer("R4 right vol", 8'hF8, 8'b111_10100);
    xfer("R5 select 001", 8'hF8, 8'b001_11111);
    xfer("R5 select 011", 8'hF8, 8'b011_11111);
    xfer("R7 power toggle", 8'hF8, 8'b000_10010);
    xfer("R3 read request", 8'hF9, 8'b101_00000);
    xfer("R3 wrong address", 8'hF0, 8'b110_11111);

    i2c_start; send_byte(8'hF8, k); send_bits(8'b110_00000, 4);
    i2c_start; send_byte(8'hF8, k); chk_bit("R6 restart ack", k, 1'b1);
    send_byte(8'b110_00001, k); i2c_stop;
    ev = model(ev, 8'b110_00001);
    chk_regs("R6 abort mid byte");

    i2c_start; send_bits(8'hF8, 5);
    i2c_start; send_byte(8'hF8, k); send_byte(8'b100_00011, k); i2c_stop;
    ev = model(ev, 8'b100_00011);
    chk_regs("R6 abort mid address");

    i2c_start; send_byte(8'hF8, k); send_byte(8'b111_01010, k);
    send_byte(8'b111_11111, k); chk_bit("R11 extra byte nack", k, 1'b0);
    i2c_stop;
    ev = model(ev, 8'b111_01010);
    chk_regs("R11 one byte only");

    pulse_low; ev = '0;
    chk_regs("R8 supply clear");

    xfer("R9 setup vol", 8'hF8, 8'b101_01111);
    xfer("R9 guard on", 8'hF8, 8'b000_00101);
    pulse_low;
    chk_regs("R9 supply ignored");
    xfer("R8 guard off", 8'hF8, 8'b000_00001);
    pulse_low; ev = '0;
    chk_regs("R8 supply clear again");

    for (int i = 0; i < 30; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 8 == 0) ? 8'hF8 ^ (8'h1 << ($urandom % 8)) : 8'hF8;
      d = 8'($urandom);
      xfer("R4 random write", a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule